// File: doc/BRIEF.md
# Dual Cascadable Countdown Timer

This block holds two 8-bit down-counters that raise periodic interrupts. Software sets both timers with one control word. For each timer that word gives a reload divider, a tick source, a mode and an interrupt-acknowledge bit. A timer in load mode stays halted and its counter takes the divider value. A timer in run mode counts down once per selected tick. When a timer passes its terminal count it reloads the divider and latches a sticky interrupt. The second timer can take the first timer's underflows as its tick source, so the two chain into one longer period.

Tick strobes come from a clock divider outside the block. They arrive as single-cycle enable pulses. An internal prescaler also runs from the core clock, and its underflow is a third tick source. Software can read the counters and the prescaler, so it can work out the time elapsed since the last interrupt. A common pattern is to read a counter, then the prescaler, then the counter again; if the two counter reads differ, a wrap happened between them.

The register bus is plain register access, not a stream. A write takes effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The bus has no back-pressure: every access completes in its own cycle.

Top module: `tmr_dual`

## Requirements
- R1: After reset both timers are halted with divider 0, source code 0 and counter 0. No interrupt is pending, and the prescaler reload and count are 0.
- R2: A control write (address 0) stores a timer's field in bits [12k+16k... ] as follows: timer k uses bits [16k+11:16k]. Bits [7:0] are the divider, [9:8] the source, bit 10 the mode (0 = load, 1 = run) and bit 11 acknowledge. A write with mode 0 halts the timer and loads its counter from the divider. While halted, ticks leave the counter unchanged.
- R3: A write with mode 1 does not reload the counter. Each selected tick then decrements it. A tick that finds the counter at 1 reloads the divider and sets the timer's interrupt, so a divider D gives one interrupt every D ticks.
- R4: A divider of 0 means 256 ticks per period. The first tick from 0 gives 255.
- R5: Source codes: 0 = `base_tick[0]`, 1 = `base_tick[1]`, 2 = prescaler underflow, 3 = underflow of timer 0 for timer 1. For timer 0, code 3 means no tick at all. Ticks of an unselected source have no effect.
- R6: With source 3 selected, timer 1 decrements exactly once per timer 0 underflow.
- R7: A control write with bit 11 = 1 in a timer's field clears that timer's pending interrupt, and bit 11 = 0 leaves it unchanged. If an underflow and a clear fall in the same cycle, the interrupt stays set.
- R8: A pending interrupt stays high until it is cleared, whatever ticks follow.
- R9: The prescaler counts down once per clock from its reload value (address 1, bits [31:0]) to 0. It reloads in the cycle after 0 and signals an underflow in that cycle, so its period is reload+1 cycles.
- R10: Reads: address 0 returns, per timer k at bits [16k+11:16k], the pending bit, mode, source and divider. Address 1 returns the prescaler reload. Address 2 returns counter k at bits [8k+7:8k] and pending bits at [17:16]. Address 3 returns the prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| base_tick | input | 2 | External tick enable strobes |
| irq | output | 2 | Sticky interrupt, one per timer |

## Verification
The bench drives a counter to 1 and then lands an underflow and an acknowledge write in the same cycle. A design that gives the clear priority would lose that interrupt. It runs a zero divider through all 256 ticks. An off-by-one terminal count would interrupt at 255 or at 257. It checks that a run-mode write leaves the count where it was. A design that reloads on every run write would restart the period, and interpolation between interrupts would then be wrong. In cascade mode it checks that timer 1 moves only on timer 0 underflows and not on the raw tick strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NTMR    = 2;
  localparam int DIV_W   = 8;
  localparam int SRC_W   = 2;
  localparam int NSRC    = 1 << SRC_W;
  localparam int FIELD_W = 16;
  localparam int BUS_W   = NTMR * FIELD_W;
  localparam int PRE_W   = BUS_W;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_CTL = 2'd0;
  localparam logic [ADDR_W-1:0] A_PRE = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT = 2'd2;
  localparam logic [ADDR_W-1:0] A_PCT = 2'd3;

  localparam logic [SRC_W-1:0] SRC_CHAIN = 2'd3;

  typedef struct packed {
    logic             clr;
    logic             run;
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
  } tctl_t;

  localparam int CTL_W = $bits(tctl_t);
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         uf
);
  logic [W-1:0] cnt_q;

  assign uf    = (cnt_q == '0);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (uf) cnt_q <= reload;
    else         cnt_q <= cnt_q - W'(1);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  tctl_t            ctl,
  input  logic [NSRC-1:0]  src_tick,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] div,
  output logic [SRC_W-1:0] src,
  output logic             run,
  output logic             uf,
  output logic             pend
);
  logic [DIV_W-1:0] cnt_q, div_q;
  logic [SRC_W-1:0] src_q;
  logic             run_q, pend_q;
  logic             load, step;

  assign load = wr_ctl & ~ctl.run;
  assign step = run_q & src_tick[src_q] & ~load;
  assign uf   = step & (cnt_q == DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      src_q <= '0;
      run_q <= 1'b0;
    end else if (wr_ctl) begin
      div_q <= ctl.div;
      src_q <= ctl.src;
      run_q <= ctl.run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= ctl.div;
    else if (uf)   cnt_q <= div_q;
    else if (step) cnt_q <= cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= uf | (pend_q & ~(wr_ctl & ctl.clr));
  end

  assign cnt  = cnt_q;
  assign div  = div_q;
  assign src  = src_q;
  assign run  = run_q;
  assign pend = pend_q;
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [1:0]        base_tick,
  output logic [NTMR-1:0]   irq
);
  localparam int PEND_LSB = FIELD_W;

  logic                        wr_ctl, wr_pre;
  logic [PRE_W-1:0]            pre_reload_q, pre_cnt;
  logic                        pre_uf;
  logic [NTMR-1:0][DIV_W-1:0]  cnt_v, div_v;
  logic [NTMR-1:0][SRC_W-1:0]  src_v;
  logic [NTMR-1:0]             run_v, uf_v, pend_v, chain_v;
  tctl_t                       ctl_v [NTMR];

  assign wr_ctl = bus_wr & (bus_addr == A_CTL);
  assign wr_pre = bus_wr & (bus_addr == A_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_reload_q <= '0;
    else if (wr_pre) pre_reload_q <= bus_wdata[PRE_W-1:0];
  end

  tmr_prescaler #(.W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (pre_reload_q),
    .count  (pre_cnt),
    .uf     (pre_uf)
  );

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    if (i == 0) begin : g_head
      assign chain_v[i] = 1'b0;
    end else begin : g_link
      assign chain_v[i] = uf_v[i-1];
    end

    assign ctl_v[i] = bus_wdata[i*FIELD_W +: CTL_W];

    tmr_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctl   (wr_ctl),
      .ctl      (ctl_v[i]),
      .src_tick ({chain_v[i], pre_uf, base_tick[1], base_tick[0]}),
      .cnt      (cnt_v[i]),
      .div      (div_v[i]),
      .src      (src_v[i]),
      .run      (run_v[i]),
      .uf       (uf_v[i]),
      .pend     (pend_v[i])
    );
  end

  assign irq = pend_v;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTL: begin
        for (int i = 0; i < NTMR; i++)
          bus_rdata[i*FIELD_W +: CTL_W] = {pend_v[i], run_v[i], src_v[i], div_v[i]};
      end
      A_PRE: bus_rdata = pre_reload_q;
      A_CNT: begin
        for (int i = 0; i < NTMR; i++) begin
          bus_rdata[i*DIV_W +: DIV_W] = cnt_v[i];
          bus_rdata[PEND_LSB + i]     = pend_v[i];
        end
      end
      default: bus_rdata = pre_cnt;
    endcase
  end
endmodule

// File: rtl/tmr_sva.sv
module tmr_sva #(
  parameter int PRE_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic             clr0,
  input logic [1:0]       irq,
  input logic [1:0]       uf_v,
  input logic [1:0]       run_v,
  input logic [15:0]      cnt_flat,
  input logic [1:0]       src1,
  input logic [PRE_W-1:0] pre_cnt
);
  logic ctl_wr;
  assign ctl_wr = bus_wr && (bus_addr == 2'd0);

  a_r3_uf_sets_irq0: assert property (@(posedge clk) disable iff (!rst_n)
    uf_v[0] |=> irq[0]);

  a_r3_uf_sets_irq1: assert property (@(posedge clk) disable iff (!rst_n)
    uf_v[1] |=> irq[1]);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[0] && !(ctl_wr && clr0)) |=> irq[0]);

  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && clr0 && !uf_v[0]) |=> !irq[0]);

  a_r2_halted_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_v[0] && !ctl_wr) |=> $stable(cnt_flat[7:0]));

  a_r6_chain_only: assert property (@(posedge clk) disable iff (!rst_n)
    (run_v[1] && src1 == 2'd3 && !ctl_wr && !uf_v[0]) |=> $stable(cnt_flat[15:8]));

  a_r9_pre_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt != '0) |=> (pre_cnt == $past(pre_cnt) - PRE_W'(1)));
endmodule

bind tmr_dual tmr_sva #(.PRE_W(tmr_pkg::PRE_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .clr0     (bus_wdata[11]),
  .irq      (irq),
  .uf_v     (uf_v),
  .run_v    (run_v),
  .cnt_flat (cnt_v),
  .src1     (src_v[1]),
  .pre_cnt  (pre_cnt)
);

// File: tb/tmr_dual_test.sv
module tmr_dual_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  base_tick = 2'b00;
  logic [1:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_dual uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .base_tick(base_tick), .irq(irq)
  );

  function automatic [31:0] cw(input [7:0] d0, input [1:0] s0, input r0, input c0,
                               input [7:0] d1, input [1:0] s1, input r1, input c1);
    cw = {4'b0, c1, r1, s1, d1, 4'b0, c0, r0, s0, d0};
  endfunction

  task automatic chk(input string req, input [31:0] got, input [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input [1:0] a, input [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input [1:0] a, output [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick(input [1:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); base_tick = m;
      @(negedge clk); base_tick = 2'b00;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d); chk("R1 ctl", d, 32'h0);
    rd(2'd1, d); chk("R1 reload", d, 32'h0);
    rd(2'd2, d); chk("R1 counts", d, 32'h0);
    rd(2'd3, d); chk("R1 prescaler", d, 32'h0);
    chk("R1 irq", {30'b0, irq}, 32'h0);
  endtask

  task automatic t_load_halt;
    logic [31:0] d;
    wr(2'd0, cw(8'd5, 2'd0, 1'b0, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0));
    rd(2'd2, d); chk("R2 load", d, 32'h5);
    tick(2'b01, 3);
    rd(2'd2, d); chk("R2 halted", d, 32'h5);
  endtask

  task automatic t_run;
    logic [31:0] d;
    wr(2'd0, cw(8'd5, 2'd0, 1'b1, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0));
    rd(2'd2, d); chk("R3 run no reload", d, 32'h5);
    tick(2'b01, 3);
    rd(2'd2, d); chk("R3 decrement", d, 32'h2);
    tick(2'b01, 1);
    chk("R3 no early irq", {30'b0, irq}, 32'h0);
    tick(2'b01, 1);
    rd(2'd2, d); chk("R3 reload", d, 32'h0001_0005);
    chk("R3 irq", {30'b0, irq}, 32'h1);
    tick(2'b10, 2);
    rd(2'd2, d); chk("R5 unselected source", d[7:0], 32'h5);
  endtask

  task automatic t_sticky_clear;
    logic [31:0] d;
    tick(2'b01, 2);
    chk("R8 sticky", {30'b0, irq}, 32'h1);
    wr(2'd0, cw(8'd5, 2'd0, 1'b1, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0));
    chk("R7 noop keeps", {30'b0, irq}, 32'h1);
    wr(2'd0, cw(8'd5, 2'd0, 1'b1, 1'b1, 8'd0, 2'd0, 1'b0, 1'b0));
    chk("R7 clear", {30'b0, irq}, 32'h0);
    rd(2'd2, d); chk("R3 count kept", d, 32'h3);
    rd(2'd0, d); chk("R10 ctl readback", d, 32'h0000_0405);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    tick(2'b01, 2);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0;
    bus_wdata = cw(8'd5, 2'd0, 1'b1, 1'b1, 8'd0, 2'd0, 1'b0, 1'b0);
    base_tick = 2'b01;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; base_tick = 2'b00;
    chk("R7 set wins", {30'b0, irq}, 32'h1);
    rd(2'd2, d); chk("R3 reload on clash", d[7:0], 32'h5);
  endtask

  task automatic t_div_zero;
    logic [31:0] d;
    wr(2'd0, cw(8'd0, 2'd0, 1'b0, 1'b1, 8'd0, 2'd0, 1'b0, 1'b0));
    wr(2'd0, cw(8'd0, 2'd0, 1'b1, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0));
    tick(2'b01, 1);
    rd(2'd2, d); chk("R4 first tick", d, 32'hFF);
    tick(2'b01, 254);
    rd(2'd2, d); chk("R4 at one", d, 32'h1);
    chk("R4 no irq at 255", {30'b0, irq}, 32'h0);
    tick(2'b01, 1);
    rd(2'd2, d); chk("R4 irq at 256", d, 32'h0001_0000);
    wr(2'd0, cw(8'd0, 2'd0, 1'b0, 1'b1, 8'd0, 2'd0, 1'b0, 1'b0));
  endtask

  task automatic t_source;
    logic [31:0] d;
    wr(2'd0, cw(8'd4, 2'd1, 1'b0, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0));
    wr(2'd0, cw(8'd4, 2'd1, 1'b1, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0));
    tick(2'b01, 2);
    rd(2'd2, d); chk("R5 tick0 ignored", d, 32'h4);
    tick(2'b10, 1);
    rd(2'd2, d); chk("R5 tick1 counts", d, 32'h3);
    wr(2'd0, cw(8'd4, 2'd3, 1'b1, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0));
    tick(2'b11, 3);
    rd(2'd2, d); chk("R5 code3 on timer0 idle", d, 32'h3);
    wr(2'd0, cw(8'd0, 2'd0, 1'b0, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0));
  endtask

  task automatic t_cascade;
    logic [31:0] d;
    wr(2'd0, cw(8'd3, 2'd0, 1'b0, 1'b0, 8'd2, 2'd3, 1'b0, 1'b0));
    wr(2'd0, cw(8'd3, 2'd0, 1'b1, 1'b0, 8'd2, 2'd3, 1'b1, 1'b0));
    tick(2'b01, 2);
    rd(2'd2, d); chk("R6 no chain yet", d, 32'h0201);
    tick(2'b01, 1);
    rd(2'd2, d); chk("R6 one chain step", d, 32'h0001_0103);
    tick(2'b01, 3);
    rd(2'd2, d); chk("R6 timer1 underflow", d, 32'h0003_0203);
    wr(2'd0, cw(8'd3, 2'd0, 1'b1, 1'b1, 8'd2, 2'd3, 1'b1, 1'b0));
    chk("R7 per-timer clear", {30'b0, irq}, 32'h2);
    wr(2'd0, cw(8'd0, 2'd0, 1'b0, 1'b0, 8'd0, 2'd0, 1'b0, 1'b1));
    rd(2'd2, d); chk("R7 all clear", d, 32'h0);
  endtask

  task automatic t_prescaler;
    logic [31:0] a, b;
    wr(2'd1, 32'd3);
    repeat (3) @(negedge clk);
    rd(2'd1, a); chk("R10 reload readback", a, 32'd3);
    rd(2'd3, a);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      rd(2'd3, b);
      chk("R9 prescaler step", b, (a == 0) ? 32'd3 : a - 1);
      a = b;
    end
    wr(2'd0, cw(8'd2, 2'd2, 1'b0, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0));
    wr(2'd0, cw(8'd2, 2'd2, 1'b1, 1'b0, 8'd0, 2'd0, 1'b0, 1'b0));
    repeat (8) @(posedge clk);
    @(negedge clk);
    rd(2'd2, a); chk("R5 prescaler source", a, 32'h0001_0002);
  endtask

  initial begin
    t_reset();
    t_load_halt();
    t_run();
    t_sticky_clear();
    t_set_wins();
    t_div_zero();
    t_source();
    t_cascade();
    t_prescaler();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule